// File: doc/BRIEF.md
# Debug Variable Capture Unit

This unit sits in the path of one tagged design signal so that the signal can be watched and steered while the design runs on hardware. Each step of the user clock (marked by `step_en`) the unit registers the live value onto its output. It also keeps a rolling window of recent samples that a host can read back by age. Every sample it records is pushed into a small local queue, and a downstream store drains that queue through a valid/ready handshake.

A host port takes one command at a time. It can read the present output, read a past sample, force a new value onto the output, or rewind the output to a past sample. A forced or rewound value either lasts for a single step or stays until it is released. Sampling can be thinned to one step in every `cfg_period+1` to save storage. When the local queue reaches a programmable fill level, the unit raises a stall request so that the clock controller can hold the user clock until the queue has drained.

The host waits for a response before it issues its next command. The history and queue depths must be powers of two.

Top module: `dbgv_unit`

## Requirements
- R1: With no override in effect, every cycle with `step_en`=1 loads `sig_in` into `sig_out`. With `step_en`=0, `sig_out` holds its value.
- R2: A command with `host_op`=0 (read current) produces `host_rsp_valid`=1 in the next cycle, with `host_rsp_data` equal to `sig_out` as it stood during the command cycle.
- R3: A command with `host_op`=1 and `host_arg`=k produces, in the next cycle, the sample recorded k captures before the newest one (k=0 is the newest). Only the last DEPTH captures are kept, in a circular buffer.
- R4: A history read or rewind with k greater than or equal to the number of valid samples sets `host_rsp_err`. The valid count saturates at DEPTH. A rewind that fails this way leaves `sig_out` untouched.
- R5: A command with `host_op`=2 and `host_sticky`=0 places `host_arg` on `sig_out` for exactly one step. That step is the first one in or after the command cycle; live tracking resumes afterwards.
- R6: A force with `host_sticky`=1 keeps its value on `sig_out` across steps until a non-sticky force arrives. The non-sticky force's own value then shows for one step.
- R7: A command with `host_op`=3 and `host_arg`=k returns the restored sample on `host_rsp_data` in the next cycle. That sample then acts as a force, one-shot or sticky according to `host_sticky`, starting with the first step from that next cycle onward.
- R8: Every captured sample enters the stream queue. Samples leave oldest first, one per cycle in which `strm_valid` and `strm_ready` are both 1.
- R9: The first step after reset is captured. After that, a capture occurs on every (`cfg_period`+1)-th step.
- R10: The step on which a forced or rewound value first drives `sig_out` is always captured, and the period count restarts from that step.
- R11: `stall_req` is 1 exactly while the queue occupancy is at least `cfg_afull`. It follows each push or pop in the cycle after it.
- R12: After reset, `sig_out` is 0, no response is shown, the queue is empty, `stall_req` is 0 and the history holds no valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | User clock step enable from the clock controller |
| sig_in | input | W | Live value of the tagged signal |
| sig_out | output | W | Value presented to the downstream design |
| cfg_period | input | PW | Capture every cfg_period+1 steps |
| cfg_afull | input | FCW | Queue fill level that raises the stall request |
| host_req_valid | input | 1 | Host command strobe |
| host_op | input | 2 | 0 read current, 1 read history, 2 force, 3 rewind |
| host_arg | input | W | Force value or history index |
| host_sticky | input | 1 | Keep the override until released |
| host_rsp_valid | output | 1 | Response strobe, one cycle after a command |
| host_rsp_err | output | 1 | History index out of range |
| host_rsp_data | output | W | Response value |
| strm_valid | output | 1 | Queue holds a sample |
| strm_ready | input | 1 | Downstream store accepts the head sample |
| strm_data | output | W | Oldest queued sample |
| stall_req | output | 1 | Request to hold the user clock |

## Verification
The bench fills the history past its depth and reads the oldest surviving entry. A pointer off by one there returns a neighbour sample or flags a valid index as an error. Forces are issued both in a stepping cycle and in a held cycle. A design that consumes the one-shot override without a step would lose the forced value, and one that fails to clear it would freeze the output. The bench also checks the streamed sequence under thinned sampling, both with and without a force in mid-period. A counter that does not restart on the override would skip the forced sample or shift every later capture. Rewind is tested both inside and past the valid count, and a design that skips the range check would drive stale memory content onto the output.

// File: rtl/dbgv_pkg.sv
package dbgv_pkg;
  typedef enum logic [1:0] {
    OP_CUR   = 2'd0,
    OP_HIST  = 2'd1,
    OP_FORCE = 2'd2,
    OP_RWND  = 2'd3
  } dbgv_op_e;
endpackage

// File: rtl/dbgv_hist.sv
module dbgv_hist #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int KW    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  input  logic [KW-1:0]                rd_k,
  output logic                         rd_ok,
  output logic [W-1:0]                 rd_q,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int XW = (KW > CW) ? KW : CW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_addr;
  logic [XW-1:0] k_x, c_x;

  assign k_x     = XW'(rd_k);
  assign c_x     = XW'(count);
  assign rd_ok   = k_x < c_x;
  assign rd_addr = wr_ptr - AW'(1) - rd_k[AW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (wr_en) begin
      wr_ptr <= wr_ptr + AW'(1);
      if (count != CW'(DEPTH)) count <= count + CW'(1);
    end
  end

  p_count_sat_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/dbgv_fifo.sv
module dbgv_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [W-1:0]                din,
  input  logic                        pop,
  output logic                        valid,
  output logic                        full,
  output logic [W-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]  occ
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign valid   = occ != '0;
  assign full    = occ == OW'(DEPTH);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + OW'(1);
        2'b01:   occ <= occ - OW'(1);
        default: occ <= occ;
      endcase
    end
  end

  p_occ_bound_r8: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(DEPTH));
  p_occ_step_r8: assert property (@(posedge clk) disable iff (rst)
    (occ == $past(occ)) || (occ == $past(occ) + OW'(1)) || (occ == $past(occ) - OW'(1)));
endmodule

// File: rtl/dbgv_pacer.sv
module dbgv_pacer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          restart,
  input  logic [PW-1:0] cfg_period,
  output logic          cap
);
  logic [PW-1:0] since;

  assign cap = step && ((since >= cfg_period) || restart);

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '1;
    end else if (step) begin
      since <= cap ? '0 : since + PW'(1);
    end else if (restart) begin
      since <= '1;
    end
  end

  p_first_cap_r9: assert property (@(posedge clk) disable iff (rst)
    (step && restart) |-> cap);
endmodule

// File: rtl/dbgv_unit.sv
module dbgv_unit
  import dbgv_pkg::*;
#(
  parameter int W      = 16,
  parameter int DEPTH  = 16,
  parameter int FDEPTH = 8,
  parameter int PW     = 8,
  parameter int FCW    = $clog2(FDEPTH+1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_en,
  input  logic [W-1:0]   sig_in,
  output logic [W-1:0]   sig_out,
  input  logic [PW-1:0]  cfg_period,
  input  logic [FCW-1:0] cfg_afull,
  input  logic           host_req_valid,
  input  logic [1:0]     host_op,
  input  logic [W-1:0]   host_arg,
  input  logic           host_sticky,
  output logic           host_rsp_valid,
  output logic           host_rsp_err,
  output logic [W-1:0]   host_rsp_data,
  output logic           strm_valid,
  input  logic           strm_ready,
  output logic [W-1:0]   strm_data,
  output logic           stall_req
);
  localparam int CW = $clog2(DEPTH+1);

  logic           is_force, is_idx, k_ok, rw_req;
  logic           rw_pend, rw_stk;
  logic           new_ovr, new_stk;
  logic [W-1:0]   new_val, eff;
  logic           ovr_act, ovr_stk;
  logic [W-1:0]   ovr_val;
  logic           cap, q_full;
  logic [W-1:0]   hist_q, cur_q;
  logic           rsp_hist;
  logic [CW-1:0]  hcount;
  logic [FCW-1:0] occ;

  assign is_force = host_req_valid && (host_op == OP_FORCE);
  assign is_idx   = host_req_valid && ((host_op == OP_HIST) || (host_op == OP_RWND));
  assign rw_req   = host_req_valid && (host_op == OP_RWND) && k_ok;

  assign new_ovr = is_force || rw_pend;
  assign new_val = is_force ? host_arg : hist_q;
  assign new_stk = is_force ? host_sticky : rw_stk;
  assign eff     = new_ovr ? new_val : (ovr_act ? ovr_val : sig_in);

  dbgv_hist #(.W(W), .DEPTH(DEPTH), .KW(W)) u_hist (
    .clk(clk), .rst(rst), .wr_en(cap), .wr_data(eff),
    .rd_en(is_idx), .rd_k(host_arg), .rd_ok(k_ok), .rd_q(hist_q), .count(hcount)
  );

  dbgv_fifo #(.W(W), .DEPTH(FDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(cap), .din(eff), .pop(strm_ready),
    .valid(strm_valid), .full(q_full), .dout(strm_data), .occ(occ)
  );

  dbgv_pacer #(.PW(PW)) u_pacer (
    .clk(clk), .rst(rst), .step(step_en), .restart(new_ovr),
    .cfg_period(cfg_period), .cap(cap)
  );

  assign stall_req = occ >= cfg_afull;

  always_ff @(posedge clk) begin
    if (rst) begin
      rw_pend <= 1'b0;
      rw_stk  <= 1'b0;
    end else begin
      rw_pend <= rw_req;
      if (rw_req) rw_stk <= host_sticky;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_act <= 1'b0;
      ovr_stk <= 1'b0;
      ovr_val <= '0;
    end else if (new_ovr) begin
      ovr_val <= new_val;
      ovr_stk <= new_stk;
      ovr_act <= new_stk || !step_en;
    end else if (step_en && ovr_act && !ovr_stk) begin
      ovr_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sig_out <= '0;
    else if (step_en) sig_out <= eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rsp_valid <= 1'b0;
      host_rsp_err   <= 1'b0;
      rsp_hist       <= 1'b0;
      cur_q          <= '0;
    end else begin
      host_rsp_valid <= host_req_valid;
      host_rsp_err   <= is_idx && !k_ok;
      rsp_hist       <= is_idx;
      if (host_req_valid) cur_q <= sig_out;
    end
  end

  assign host_rsp_data = rsp_hist ? hist_q : cur_q;

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(sig_out));
  p_rsp_req_r2: assert property (@(posedge clk) disable iff (rst)
    host_rsp_valid |-> $past(host_req_valid));
  p_err_src_r4: assert property (@(posedge clk) disable iff (rst)
    host_rsp_err |-> $past(is_idx));
  p_force_next_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && is_force) |=> (sig_out == $past(host_arg)));
  p_full_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (q_full && (cfg_afull <= FCW'(FDEPTH))) |-> stall_req);
  p_hcount_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rsp_valid && !host_rsp_err && $past(host_op == OP_HIST)) |-> ($past(hcount) != '0));
endmodule

// File: tb/dbgv_unit_test.sv
module dbgv_unit_test;
  localparam int W = 16, DEPTH = 16, FDEPTH = 8, PW = 8;
  localparam int FCW = $clog2(FDEPTH+1);

  logic clk = 1'b0, rst = 1'b1;
  logic step_en = 1'b0;
  logic [W-1:0] sig_in = '0;
  logic [W-1:0] sig_out;
  logic [PW-1:0] cfg_period = '0;
  logic [FCW-1:0] cfg_afull = FCW'(FDEPTH);
  logic host_req_valid = 1'b0;
  logic [1:0] host_op = '0;
  logic [W-1:0] host_arg = '0;
  logic host_sticky = 1'b0;
  logic host_rsp_valid, host_rsp_err;
  logic [W-1:0] host_rsp_data;
  logic strm_valid, strm_ready = 1'b0, stall_req;
  logic [W-1:0] strm_data;

  int total = 0, bad = 0, cyc = 0;
  bit over = 1'b0;

  always #2 clk = ~clk;

  dbgv_unit #(.W(W), .DEPTH(DEPTH), .FDEPTH(FDEPTH), .PW(PW)) uut (
    .clk(clk), .rst(rst), .step_en(step_en), .sig_in(sig_in), .sig_out(sig_out),
    .cfg_period(cfg_period), .cfg_afull(cfg_afull),
    .host_req_valid(host_req_valid), .host_op(host_op), .host_arg(host_arg),
    .host_sticky(host_sticky), .host_rsp_valid(host_rsp_valid),
    .host_rsp_err(host_rsp_err), .host_rsp_data(host_rsp_data),
    .strm_valid(strm_valid), .strm_ready(strm_ready), .strm_data(strm_data),
    .stall_req(stall_req)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(int period, int afull);
    rst = 1'b1; step_en = 1'b0; host_req_valid = 1'b0; strm_ready = 1'b0;
    sig_in = '0; host_sticky = 1'b0;
    cfg_period = PW'(period); cfg_afull = FCW'(afull);
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic step(int v);
    sig_in = W'(v); step_en = 1'b1;
    tick();
    step_en = 1'b0;
  endtask

  task automatic cmd(int op, int arg, bit stk);
    host_req_valid = 1'b1; host_op = 2'(op); host_arg = W'(arg); host_sticky = stk;
    tick();
    host_req_valid = 1'b0; host_sticky = 1'b0;
  endtask

  task automatic pop_expect(string tag, int exp);
    chk({tag, " valid"}, int'(strm_valid), 1);
    chk({tag, " data"}, int'(strm_data), exp);
    strm_ready = 1'b1;
    tick();
    strm_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(0, FDEPTH);
    chk("R12 sig_out", int'(sig_out), 0);
    chk("R12 rsp_valid", int'(host_rsp_valid), 0);
    chk("R12 strm_valid", int'(strm_valid), 0);
    chk("R12 stall", int'(stall_req), 0);
    cmd(1, 0, 1'b0);
    chk("R12 empty history err", int'(host_rsp_err), 1);
  endtask

  task automatic t_pass();
    do_reset(0, FDEPTH);
    step(16'h1234);
    chk("R1 follow", int'(sig_out), 16'h1234);
    sig_in = 16'h5555;
    tick();
    chk("R1 hold", int'(sig_out), 16'h1234);
    cmd(0, 0, 1'b0);
    chk("R2 valid", int'(host_rsp_valid), 1);
    chk("R2 data", int'(host_rsp_data), 16'h1234);
  endtask

  task automatic t_hist();
    do_reset(0, FDEPTH);
    for (int i = 1; i <= 5; i++) step(i);
    cmd(1, 0, 1'b0);
    chk("R3 newest", int'(host_rsp_data), 5);
    cmd(1, 4, 1'b0);
    chk("R3 oldest", int'(host_rsp_data), 1);
    chk("R3 no err", int'(host_rsp_err), 0);
    cmd(1, 5, 1'b0);
    chk("R4 beyond count", int'(host_rsp_err), 1);
    for (int i = 6; i <= 19; i++) step(i);
    cmd(1, DEPTH - 1, 1'b0);
    chk("R3 wrapped oldest", int'(host_rsp_data), 19 - (DEPTH - 1));
    chk("R3 wrapped ok", int'(host_rsp_err), 0);
    cmd(1, DEPTH, 1'b0);
    chk("R4 saturated count", int'(host_rsp_err), 1);
  endtask

  task automatic t_stream();
    do_reset(0, 3);
    step(11); step(22);
    chk("R11 below level", int'(stall_req), 0);
    chk("R8 head", int'(strm_data), 11);
    step(33);
    chk("R11 at level", int'(stall_req), 1);
    pop_expect("R8 first", 11);
    chk("R11 after pop", int'(stall_req), 0);
    pop_expect("R8 second", 22);
    pop_expect("R8 third", 33);
    chk("R8 drained", int'(strm_valid), 0);
  endtask

  task automatic t_force();
    do_reset(0, FDEPTH);
    sig_in = 7; step_en = 1'b1;
    cmd(2, 99, 1'b0);
    chk("R5 forced", int'(sig_out), 99);
    tick();
    chk("R5 released", int'(sig_out), 7);
    step_en = 1'b0;
    cmd(2, 44, 1'b0);
    chk("R5 held no step", int'(sig_out), 7);
    step(7);
    chk("R5 pending applied", int'(sig_out), 44);
    step(7);
    chk("R5 pending released", int'(sig_out), 7);
  endtask

  task automatic t_sticky();
    do_reset(0, FDEPTH);
    sig_in = 8; step_en = 1'b1;
    cmd(2, 55, 1'b1);
    step_en = 1'b0;
    chk("R6 sticky set", int'(sig_out), 55);
    step(8);
    chk("R6 sticky step1", int'(sig_out), 55);
    step(9);
    chk("R6 sticky step2", int'(sig_out), 55);
    sig_in = 9; step_en = 1'b1;
    cmd(2, 66, 1'b0);
    step_en = 1'b0;
    chk("R6 release value", int'(sig_out), 66);
    step(9);
    chk("R6 live again", int'(sig_out), 9);
  endtask

  task automatic t_rewind();
    do_reset(0, FDEPTH);
    step(10); step(20); step(30);
    cmd(3, 2, 1'b0);
    chk("R7 rsp data", int'(host_rsp_data), 10);
    chk("R7 rsp ok", int'(host_rsp_err), 0);
    tick();
    chk("R7 waits for step", int'(sig_out), 30);
    step(40);
    chk("R7 restored", int'(sig_out), 10);
    step(40);
    chk("R7 one shot", int'(sig_out), 40);
    cmd(3, 9, 1'b0);
    chk("R4 rewind err", int'(host_rsp_err), 1);
    tick();
    step(50);
    chk("R4 rewind no effect", int'(sig_out), 50);
  endtask

  task automatic t_period();
    do_reset(2, FDEPTH);
    for (int s = 0; s <= 8; s++) step(s);
    pop_expect("R9 cap a", 0);
    pop_expect("R9 cap b", 3);
    pop_expect("R9 cap c", 6);
    chk("R9 no extra", int'(strm_valid), 0);
  endtask

  task automatic t_restart();
    do_reset(2, FDEPTH);
    step(0); step(1);
    sig_in = 2; step_en = 1'b1;
    cmd(2, 100, 1'b0);
    step_en = 1'b0;
    step(3); step(4); step(5);
    pop_expect("R10 before", 0);
    pop_expect("R10 forced captured", 100);
    pop_expect("R10 restarted", 5);
    chk("R10 no extra", int'(strm_valid), 0);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_hist();
    t_stream();
    t_force();
    t_sticky();
    t_rewind();
    t_period();
    t_restart();
    if (!over) begin
      over = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !over) begin
        over = 1'b1;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule